// File: doc/BRIEF.md
# Flash Bus-Write Command Decoder

This block watches the host's write cycles to a parallel NOR-style flash and turns the multi-cycle unlock sequences into single decoded operations. Every accepted write carries an address and a data word. The block compares the address and the low data byte against the pattern that the current step of a sequence expects. When a sequence completes, it emits a one-cycle operation strobe. The strobe carries an operation code together with the address and data of the final write. The operations are reset, program, chip erase, block erase, ID read, hidden-area entry and exit, query, fast-program set and reset, suspend and resume.

A mode input selects word or byte addressing for each write, and with it the unlock address pattern. A busy input from the embedded-operation controller limits what can be recognised while an operation runs. Three mode flags are visible as plain outputs: fast-program, hidden-area and suspended. A write that breaks a sequence sends the decoder back to its idle (read) state and produces no strobe.

The write side is a valid/ready stream. `wr_ready` is held high, so the host is never stalled and a write transfers on every cycle with `wr_valid` high. The operation side is valid-only. The consumer cannot apply back-pressure and must take each strobe in the cycle it appears.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `op_valid` is 0, all three flags are 0, the decoder is idle and `wr_ready` is 1 in every cycle.
- R2: In idle, a single write whose low data byte is F0h, at any address, yields op code 1 (reset). The upper data byte plays no part in command matching. In word mode `op_data` carries all 16 data bits; in byte mode its upper byte is 0.
- R3: Unlock is data AAh and then data 55h. The addresses are 555h then 2AAh on the low 11 address bits in word mode, and AAAh then 555h on the low 12 bits in byte mode. Higher address bits are ignored. Unlock, then A0h at the first unlock address, then any write yields op code 2 (program), carrying that last write's address and data.
- R4: Unlock, 80h at the unlock address, and unlock again are followed by a final write. A final 10h at the unlock address yields op code 3 (chip erase). A final 30h at any address yields op code 4 (block erase), carrying that address.
- R5: Unlock followed by 90h at the unlock address, with any higher bank bits, yields op code 5 (ID read) carrying that address, as long as the hidden flag is clear.
- R6: Unlock followed by 88h yields op code 6 and sets the hidden flag. While the hidden flag is set, unlock, then 90h, then 00h at any address yields op code 7 and clears the flag. Any other data after the 90h yields nothing and leaves the flag set.
- R7: In idle, 98h at low address 55h (word mode) or AAh (byte mode) yields op code 8 (query). At any other address it yields nothing.
- R8: Unlock followed by 20h yields op code 9 and sets the fast flag. While the flag is set, A0h followed by any write yields op code 2. A write of 90h followed by F0h or 00h yields op code 10 and clears the flag.
- R9: While `busy` is high and the suspended flag is clear, B0h at any address yields op code 11 and sets the suspended flag. A B0h write with `busy` low yields nothing. While the suspended flag is set, 30h yields op code 12 and clears the flag; without the flag, 30h yields nothing.
- R10: While `busy` is high, every write other than an accepted suspend yields no strobe and does not start a sequence.
- R11: A write that does not match the current step's expected address and data returns the decoder to idle without a strobe.
- R12: `op_valid` rises for exactly the cycle after the write that completes an operation, and only after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | ADDR_W | Write address (word or byte units per `byte_mode`) |
| wr_data | input | 16 | Write data |
| byte_mode | input | 1 | 1 selects byte addressing for this write |
| busy | input | 1 | Embedded operation running |
| op_valid | output | 1 | One-cycle operation strobe |
| op_code | output | 4 | Decoded operation code |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | 16 | Data of the completing write |
| fast_mode | output | 1 | Fast-program flag |
| hidden_mode | output | 1 | Hidden-area flag |
| suspended | output | 1 | Suspended flag |

## Verification
The bench builds the decoder with ADDR_W = 14. At that width two bank bits sit above the 12 compared bits, so the test that upper address bits are ignored covers every bank value cheaply, and a reset write can be swept across the address space in a few thousand cycles. With this small setting the bench also sweeps all 256 third-cycle command bytes in both addressing modes. It sweeps every byte written while busy as well, so every unlisted code is shown to yield no strobe.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_RESET       = 4'd1,
    OP_PROGRAM     = 4'd2,
    OP_CHIP_ERASE  = 4'd3,
    OP_BLOCK_ERASE = 4'd4,
    OP_ID_READ     = 4'd5,
    OP_HIDDEN_IN   = 4'd6,
    OP_HIDDEN_OUT  = 4'd7,
    OP_QUERY       = 4'd8,
    OP_FAST_SET    = 4'd9,
    OP_FAST_CLR    = 4'd10,
    OP_SUSPEND     = 4'd11,
    OP_RESUME      = 4'd12
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLK1, ST_UNLK2, ST_PROG, ST_ERS1, ST_ERS2,
    ST_ERS3, ST_EXIT, ST_FPROG, ST_FCLR
  } st_e;

  localparam logic [7:0] C_UNLK1   = 8'hAA;
  localparam logic [7:0] C_UNLK2   = 8'h55;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_BLOCK   = 8'h30;
  localparam logic [7:0] C_ID      = 8'h90;
  localparam logic [7:0] C_HID     = 8'h88;
  localparam logic [7:0] C_FAST    = 8'h20;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_RESUME  = 8'h30;
  localparam logic [7:0] C_ZERO    = 8'h00;

  // flag vector positions
  localparam int F_FAST = 0;
  localparam int F_HID  = 1;
  localparam int F_SUSP = 2;
  localparam int NFLAGS = 3;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match #(
  parameter int UNLK_W = 11,
  parameter logic [UNLK_W:0] U1_WORD = 12'h555,
  parameter logic [UNLK_W:0] U2_WORD = 12'h2AA,
  parameter logic [UNLK_W:0] Q_WORD  = 12'h055,
  parameter logic [UNLK_W:0] U1_BYTE = 12'hAAA,
  parameter logic [UNLK_W:0] U2_BYTE = 12'h555,
  parameter logic [UNLK_W:0] Q_BYTE  = 12'h0AA
) (
  input  logic [UNLK_W:0] addr_lo,
  input  logic            byte_mode,
  output logic            hit_u1,
  output logic            hit_u2,
  output logic            hit_q
);
  localparam int BW = UNLK_W + 1;

  logic [BW-1:0] cmp_addr;

  // word mode compares only the low UNLK_W bits
  assign cmp_addr = byte_mode ? addr_lo : {1'b0, addr_lo[UNLK_W-1:0]};

  assign hit_u1 = cmp_addr == (byte_mode ? U1_BYTE : U1_WORD);
  assign hit_u2 = cmp_addr == (byte_mode ? U2_BYTE : U2_WORD);
  assign hit_q  = cmp_addr == (byte_mode ? Q_BYTE  : Q_WORD);
endmodule

// File: rtl/flash_cmd_flags.sv
module flash_cmd_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_o[i] <= 1'b0;
      else if (clr_i[i])  flag_o[i] <= 1'b0;
      else if (set_i[i])  flag_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       data,
  input  logic              byte_mode,
  input  logic              busy,
  input  logic              hit_u1,
  input  logic              hit_u2,
  input  logic              hit_q,
  input  logic [NFLAGS-1:0] flags,
  output logic [NFLAGS-1:0] set_o,
  output logic [NFLAGS-1:0] clr_o,
  output logic              op_valid,
  output logic [3:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_data
);
  st_e        st, st_n;
  op_e        op_n;
  logic [7:0] cmd;

  assign cmd = data[7:0];

  always_comb begin
    st_n  = st;
    op_n  = OP_NONE;
    set_o = '0;
    clr_o = '0;
    if (fire) begin
      st_n = ST_IDLE;
      unique case (st)
        ST_IDLE: begin
          if (busy) begin
            if (cmd == C_SUSPEND && !flags[F_SUSP]) begin
              op_n = OP_SUSPEND;
              set_o[F_SUSP] = 1'b1;
            end
          end else if (flags[F_SUSP] && cmd == C_RESUME) begin
            op_n = OP_RESUME;
            clr_o[F_SUSP] = 1'b1;
          end else if (cmd == C_RESET) begin
            op_n = OP_RESET;
          end else if (flags[F_FAST] && cmd == C_PROG) begin
            st_n = ST_FPROG;
          end else if (flags[F_FAST] && cmd == C_ID) begin
            st_n = ST_FCLR;
          end else if (cmd == C_UNLK1 && hit_u1) begin
            st_n = ST_UNLK1;
          end else if (cmd == C_QUERY && hit_q) begin
            op_n = OP_QUERY;
          end
        end
        ST_UNLK1: if (cmd == C_UNLK2 && hit_u2) st_n = ST_UNLK2;
        ST_UNLK2: begin
          if (hit_u1) begin
            case (cmd)
              C_PROG:  st_n = ST_PROG;
              C_ERASE: st_n = ST_ERS1;
              C_ID: begin
                if (flags[F_HID]) st_n = ST_EXIT;
                else              op_n = OP_ID_READ;
              end
              C_HID: begin
                op_n = OP_HIDDEN_IN;
                set_o[F_HID] = 1'b1;
              end
              C_FAST: begin
                op_n = OP_FAST_SET;
                set_o[F_FAST] = 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_PROG, ST_FPROG: op_n = OP_PROGRAM;
        ST_ERS1: if (cmd == C_UNLK1 && hit_u1) st_n = ST_ERS2;
        ST_ERS2: if (cmd == C_UNLK2 && hit_u2) st_n = ST_ERS3;
        ST_ERS3: begin
          if (cmd == C_CHIP && hit_u1) op_n = OP_CHIP_ERASE;
          else if (cmd == C_BLOCK)     op_n = OP_BLOCK_ERASE;
        end
        ST_EXIT: begin
          if (cmd == C_ZERO) begin
            op_n = OP_HIDDEN_OUT;
            clr_o[F_HID] = 1'b1;
          end
        end
        ST_FCLR: begin
          if (cmd == C_RESET || cmd == C_ZERO) begin
            op_n = OP_FAST_CLR;
            clr_o[F_FAST] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_valid <= 1'b0;
      op_code  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      st       <= st_n;
      op_valid <= op_n != OP_NONE;
      op_code  <= op_n;
      if (op_n != OP_NONE) begin
        op_addr <= addr;
        op_data <= byte_mode ? {8'h00, data[7:0]} : data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int UNLK_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              byte_mode,
  input  logic              busy,
  output logic              op_valid,
  output logic [3:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_data,
  output logic              fast_mode,
  output logic              hidden_mode,
  output logic              suspended
);
  logic              fire;
  logic              hit_u1, hit_u2, hit_q;
  logic [NFLAGS-1:0] flags, set_v, clr_v;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid && wr_ready;

  flash_cmd_match #(.UNLK_W(UNLK_W)) u_match (
    .addr_lo  (wr_addr[UNLK_W:0]),
    .byte_mode(byte_mode),
    .hit_u1   (hit_u1),
    .hit_u2   (hit_u2),
    .hit_q    (hit_q)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .addr     (wr_addr),
    .data     (wr_data),
    .byte_mode(byte_mode),
    .busy     (busy),
    .hit_u1   (hit_u1),
    .hit_u2   (hit_u2),
    .hit_q    (hit_q),
    .flags    (flags),
    .set_o    (set_v),
    .clr_o    (clr_v),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_addr  (op_addr),
    .op_data  (op_data)
  );

  flash_cmd_flags #(.N(NFLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .flag_o(flags)
  );

  assign fast_mode   = flags[F_FAST];
  assign hidden_mode = flags[F_HID];
  assign suspended   = flags[F_SUSP];
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int ADDR_W = 22
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        byte_mode,
  input logic        busy,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [15:0] op_data,
  input logic        fast_mode,
  input logic        hidden_mode,
  input logic        suspended
);
  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_valid)); // R12
  AST_STROBE_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_code != 4'd0 && op_code <= 4'd12)); // R12
  AST_BYTE_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && $past(byte_mode)) |-> op_data[15:8] == 8'h00); // R2
  AST_HIDDEN_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd6) |-> hidden_mode); // R6
  AST_HIDDEN_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd7) |-> !hidden_mode); // R6
  AST_FAST_SET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd9) |-> fast_mode); // R8
  AST_FAST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd10) |-> !fast_mode); // R8
  AST_SUSPEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd11) |-> ($past(busy) && suspended)); // R9
  AST_RESUME_NEEDS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd12) |-> $past(suspended)); // R9
  AST_BUSY_ONLY_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && $past(busy)) |-> op_code == 4'd11); // R10
endmodule

bind flash_cmd_decoder flash_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .byte_mode  (byte_mode),
  .busy       (busy),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .op_data    (op_data),
  .fast_mode  (fast_mode),
  .hidden_mode(hidden_mode),
  .suspended  (suspended)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic byte_mode = 1'b0;
  logic busy = 1'b0;
  logic op_valid;
  logic [3:0] op_code;
  logic [AW-1:0] op_addr;
  logic [15:0] op_data;
  logic fast_mode, hidden_mode, suspended;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .byte_mode(byte_mode), .busy(busy),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
    .fast_mode(fast_mode), .hidden_mode(hidden_mode), .suspended(suspended)
  );

  function automatic logic [AW-1:0] u1(input int bank);
    return AW'(bank << 12) | (byte_mode ? AW'('hAAA) : AW'('h555));
  endfunction
  function automatic logic [AW-1:0] u2(input int bank);
    return AW'(bank << 12) | (byte_mode ? AW'('h555) : AW'('h2AA));
  endfunction
  function automatic logic [15:0] xd(input logic [15:0] d);
    return byte_mode ? {8'h00, d[7:0]} : d;
  endfunction

  task automatic bit_chk(input logic act, input logic exp, input string rq);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", rq, act, exp);
    end
  endtask

  // one write; result sampled at the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                    input logic [3:0] ec, input logic [AW-1:0] ea,
                    input logic [15:0] ed, input string rq);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    n_cmp++;
    if (ec == 4'd0) begin
      if (op_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL %s: actual valid=%b code=%0d expected no strobe", rq, op_valid, op_code);
      end
    end else if (op_valid !== 1'b1 || op_code !== ec || op_addr !== ea || op_data !== ed) begin
      n_bad++;
      $display("FAIL %s: actual v=%b c=%0d a=%h d=%h expected v=1 c=%0d a=%h d=%h",
               rq, op_valid, op_code, op_addr, op_data, ec, ea, ed);
    end
  endtask

  task automatic nw(input logic [AW-1:0] a, input logic [15:0] d, input string rq);
    wr(a, d, 4'd0, '0, '0, rq);
  endtask

  task automatic unlock(input int bank, input string rq);
    nw(u1(bank), 16'h00AA, rq);
    nw(u2(bank), 16'h0055, rq);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bit_chk(op_valid, 1'b0, "R1");
    bit_chk(fast_mode, 1'b0, "R1");
    bit_chk(hidden_mode, 1'b0, "R1");
    bit_chk(suspended, 1'b0, "R1");
    bit_chk(wr_ready, 1'b1, "R1");

    // R2 reset write across the address space, both modes
    for (int m = 0; m < 2; m++) begin
      byte_mode = m[0];
      for (int a = 0; a < (1 << AW); a += 61) begin
        logic [15:0] d;
        d = {8'(a * 7 + 3), 8'hF0};
        wr(AW'(a), d, 4'd1, AW'(a), xd(d), "R2");
      end
    end

    // R3 program in both modes across banks; R11 wrong-mode pattern
    for (int m = 0; m < 2; m++) begin
      byte_mode = m[0];
      for (int b = 0; b < 4; b++) begin
        logic [AW-1:0] pa;
        pa = AW'(b * 1234 + 77);
        unlock(b, "R3");
        nw(u1(3 - b), 16'h77A0, "R3");
        wr(pa, 16'hC3 + 16'(b << 9), 4'd2, pa, xd(16'hC3 + 16'(b << 9)), "R3");
      end
    end
    byte_mode = 1'b1;
    nw(AW'('h555), 16'h00AA, "R11");
    nw(AW'('h2AA), 16'h0055, "R11");
    nw(AW'('h555), 16'h00A0, "R11");
    nw(AW'('h123), 16'h0042, "R11");

    // R11/R5/R6/R8 sweep of the third command byte
    for (int m = 0; m < 2; m++) begin
      byte_mode = m[0];
      for (int c = 0; c < 256; c++) begin
        logic [3:0] ec;
        ec = (c == 'h90) ? 4'd5 : (c == 'h88) ? 4'd6 : (c == 'h20) ? 4'd9 : 4'd0;
        unlock(1, "R11");
        wr(u1(2), {8'h5A, 8'(c)}, ec, u1(2), xd({8'h5A, 8'(c)}), "R11 third-cycle sweep");
        if (c == 'hA0) wr(AW'(0), 16'h0000, 4'd2, AW'(0), 16'h0000, "R3 sweep");
        else           nw(AW'(0), 16'h0000, "R11 sweep follow-up");
        if (c == 'h88) begin
          unlock(0, "R6");
          nw(u1(0), 16'h0090, "R6");
          wr(AW'(9), 16'h0000, 4'd7, AW'(9), 16'h0000, "R6 exit");
        end
        if (c == 'h20) begin
          nw(AW'(5), 16'h0090, "R8");
          wr(AW'(5), 16'h0000, 4'd10, AW'(5), 16'h0000, "R8 clear");
        end
      end
      bit_chk(hidden_mode, 1'b0, "R6");
      bit_chk(fast_mode, 1'b0, "R8");
    end

    // R4 erase, and R11 break at each step
    for (int m = 0; m < 2; m++) begin
      byte_mode = m[0];
      unlock(0, "R4"); nw(u1(0), 16'h0080, "R4"); unlock(1, "R4");
      wr(u1(3), 16'h0010, 4'd3, u1(3), 16'h0010, "R4 chip");
      unlock(0, "R4"); nw(u1(0), 16'h0080, "R4"); unlock(0, "R4");
      wr(AW'('h2ABC), 16'hEE30, 4'd4, AW'('h2ABC), xd(16'hEE30), "R4 block");
      unlock(0, "R4"); nw(u1(0), 16'h0080, "R4"); unlock(0, "R4");
      nw(AW'('h0123), 16'h0010, "R4 chip at wrong address");
      for (int k = 0; k < 5; k++) begin
        if (k == 0) nw(u2(0), 16'h00AA, "R11"); else nw(u1(0), 16'h00AA, "R11");
        if (k == 1) nw(u1(0), 16'h0055, "R11"); else nw(u2(0), 16'h0055, "R11");
        if (k == 2) nw(u2(0), 16'h0080, "R11"); else nw(u1(0), 16'h0080, "R11");
        if (k == 3) nw(u1(0), 16'h00AB, "R11"); else nw(u1(0), 16'h00AA, "R11");
        if (k == 4) nw(u2(0), 16'h0054, "R11"); else nw(u2(0), 16'h0055, "R11");
        nw(u1(0), 16'h0010, "R11 broken erase yields nothing");
      end
    end

    // R6 non-zero after 90h in hidden mode
    byte_mode = 1'b0;
    unlock(0, "R6"); wr(u1(0), 16'h0088, 4'd6, u1(0), 16'h0088, "R6 entry");
    bit_chk(hidden_mode, 1'b1, "R6");
    unlock(0, "R6"); nw(u1(0), 16'h0090, "R6"); nw(AW'(3), 16'h0001, "R6");
    bit_chk(hidden_mode, 1'b1, "R6");
    unlock(0, "R6"); nw(u1(0), 16'h0090, "R6");
    wr(AW'(3), 16'hFF00, 4'd7, AW'(3), 16'hFF00, "R6 exit");
    bit_chk(hidden_mode, 1'b0, "R6");

    // R7 query
    for (int m = 0; m < 2; m++) begin
      byte_mode = m[0];
      for (int b = 0; b < 4; b++) begin
        logic [AW-1:0] qa;
        qa = AW'(b << 12) | (byte_mode ? AW'('hAA) : AW'('h55));
        wr(qa, 16'h0098, 4'd8, qa, 16'h0098, "R7");
        nw(qa + AW'(2), 16'h0098, "R7 wrong address");
      end
    end

    // R8 fast program, both clear codes
    byte_mode = 1'b0;
    for (int k = 0; k < 2; k++) begin
      unlock(0, "R8"); wr(u1(0), 16'h0020, 4'd9, u1(0), 16'h0020, "R8 set");
      bit_chk(fast_mode, 1'b1, "R8");
      for (int j = 0; j < 4; j++) begin
        nw(AW'(j), 16'h00A0, "R8");
        wr(AW'(j * 999), 16'(j * 4111), 4'd2, AW'(j * 999), 16'(j * 4111), "R8 program");
      end
      nw(AW'(1), 16'h0090, "R8");
      wr(AW'(1), (k == 0) ? 16'h00F0 : 16'h0000, 4'd10, AW'(1),
         (k == 0) ? 16'h00F0 : 16'h0000, "R8 clear");
      bit_chk(fast_mode, 1'b0, "R8");
      nw(AW'(2), 16'h00A0, "R8 off");
      nw(AW'(2), 16'h0042, "R8 off: no program");
    end

    // R9 suspend/resume rules, R10 busy sweep
    nw(AW'(4), 16'h00B0, "R9 suspend without busy");
    nw(AW'(4), 16'h0030, "R9 resume without suspend");
    bit_chk(suspended, 1'b0, "R9");
    busy = 1'b1;
    byte_mode = 1'b0;
    for (int c = 0; c < 256; c++) begin
      if (c == 'hB0) wr(AW'('h1555), 16'h00B0, 4'd11, AW'('h1555), 16'h00B0, "R9 suspend");
      else           nw(AW'('h555), {8'h00, 8'(c)}, "R10 ignored while busy");
    end
    bit_chk(suspended, 1'b1, "R9");
    nw(u2(0), 16'h0055, "R10"); nw(u1(0), 16'h00A0, "R10");
    nw(AW'(8), 16'h0012, "R10 no sequence started");
    busy = 1'b0;
    nw(u2(0), 16'h0055, "R10"); nw(u1(0), 16'h00A0, "R10");
    nw(AW'(8), 16'h0012, "R10 no sequence started");
    wr(AW'('h2000), 16'h0030, 4'd12, AW'('h2000), 16'h0030, "R9 resume");
    bit_chk(suspended, 1'b0, "R9");

    // R12 strobe lasts one cycle
    wr(AW'(0), 16'h00F0, 4'd1, AW'(0), 16'h00F0, "R12");
    @(negedge clk);
    bit_chk(op_valid, 1'b0, "R12");
    bit_chk(wr_ready, 1'b1, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule